// File: doc/BRIEF.md
# Network Interface with Routing Table

This block connects one hardware task to its local router in a packet-switched on-chip network. On the send side the task gives a logical destination address, a port number, a length and the data flits. The block stores the whole message in an output buffer and looks up the destination in a routing table that can be rewritten while traffic runs. The lookup gives the relative X and Y hop counts. Once the message is fully stored, the block sends it to the router as a framed message: an X header, a Y header, the data and two tail flits.

On the receive side the router delivers frames whose X header has already been removed. The block keeps each frame in one of a small ring of input buffers and records the data length, the sending node and the port next to that buffer. It then presents the messages to the task in the order they arrived. If every input buffer still holds a message that has not been fully read, the block applies back-pressure toward the router.

Top module: `network_iface`

## Requirements
- R1: For a message whose first flit is accepted, the X header flit carries the table's X hop count in bits [3:0] with all higher bits zero. The Y header flit carries the table's Y hop count in bits [3:0], the message port in bits [7:4] and the NODE_ID parameter in bits [15:8]. Both come from the table entry selected by `mo_dst` in the cycle the first flit is accepted.
- R2: A table write takes effect for every message whose first flit is accepted after the write cycle. A write never changes a message already accepted, and it never lowers `mo_ready`.
- R3: If the selected table entry is not valid, `mo_err` is high for exactly the cycle after the first flit is accepted. The message's flits are still accepted, and none of it appears on the network side.
- R4: A sent frame is, in order: the X header, the Y header, the data flits in acceptance order, a tail flit equal to the data length, and a tail flit equal to the bitwise inverse of that length. `net_tx_last` is high only with the second tail flit.
- R5: `net_tx_valid` stays low while a message is being written and no earlier message is waiting. It rises in the cycle after the last data flit is accepted.
- R6: Two complete messages can wait for the network. While both wait, `mo_ready` is low. Messages leave in the order they were accepted.
- R7: While `net_tx_nack` is high, the presented flit and `net_tx_last` hold unchanged and `net_tx_valid` stays high.
- R8: An incoming frame is the Y header, then the data flits, then two tail flits, with `net_rx_last` high on the final one. The task sees `mi_len` equal to the data flit count, `mi_origin` equal to Y header bits [15:8], `mi_port` equal to bits [7:4], and the data in order. `mi_last` is high on the final data flit.
- R9: `net_rx_nack` is high in the cycle after the second input buffer is filled and neither buffer has been fully read. It falls in the cycle after the task takes the last flit of a buffered message.
- R10: Received messages are handed to the task in arrival order.
- R11: While `mi_valid` is high and `mi_ready` is low, all message-in outputs hold their values.
- R12: After reset, `net_tx_valid`, `mi_valid`, `net_rx_nack` and `mo_err` are low, `mo_ready` is high, and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Write one routing table entry |
| tbl_wr_addr | input | LADDR_W | Logical address of the entry to write |
| tbl_wr_vld | input | 1 | Valid bit stored with the entry |
| tbl_wr_x | input | 4 | X hop count for the entry |
| tbl_wr_y | input | 4 | Y hop count for the entry |
| mo_valid | input | 1 | Task offers an outgoing data flit |
| mo_ready | output | 1 | An output buffer can take the flit |
| mo_dst | input | LADDR_W | Logical destination, sampled with the first flit |
| mo_port | input | 4 | Destination port, sampled with the first flit |
| mo_len | input | clog2(MAX_LEN+1) | Data flit count (1..MAX_LEN), sampled with the first flit |
| mo_data | input | 16 | Outgoing data flit |
| mo_err | output | 1 | One-cycle pulse on a routing table miss |
| net_tx_valid | output | 1 | A flit is offered to the router |
| net_tx_nack | input | 1 | Router back-pressure; the offered flit is not taken |
| net_tx_flit | output | 16 | Flit toward the router |
| net_tx_last | output | 1 | Final flit of the frame |
| net_rx_valid | input | 1 | Router offers an incoming flit |
| net_rx_nack | output | 1 | No input buffer is free |
| net_rx_flit | input | 16 | Flit from the router |
| net_rx_last | input | 1 | Final flit of the incoming frame |
| mi_valid | output | 1 | An incoming data flit is presented to the task |
| mi_ready | input | 1 | Task takes the presented flit |
| mi_len | output | clog2(MAX_LEN+1) | Data length of the presented message |
| mi_origin | output | 8 | Sending node of the presented message |
| mi_port | output | 4 | Port of the presented message |
| mi_data | output | 16 | Presented data flit |
| mi_last | output | 1 | Final data flit of the presented message |

## Verification
All inputs change on the falling clock edge. Outputs are read one nanosecond later, so each check sees the state that the preceding rising edge left behind. A miss pulse is read at the first falling edge after the edge that took the first flit. The start of transmission and the rise and fall of receive back-pressure are read at the falling edge right after the accepting edge, because each of these follows a single register update. Handshakes wait until valid and ready, or valid and no back-pressure, hold together before any flit is compared. This keeps every comparison correct under random stalls.

// File: rtl/ni_pkg.sv
package ni_pkg;

    localparam int FLIT_W      = 16;
    localparam int HOP_W       = 4;
    localparam int PORT_W      = 4;
    localparam int NODE_W      = 8;
    localparam int MAX_LEN_DEF = 128;
    localparam int NBUF_DEF    = 2;
    localparam int LADDR_W_DEF = 3;

    typedef logic [FLIT_W-1:0] flit_t;
    typedef logic [HOP_W-1:0]  hop_t;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [NODE_W-1:0] node_t;

    // One routing table entry: relative hop counts for a logical address
    typedef struct packed {
        logic vld;
        hop_t xh;
        hop_t yh;
    } route_t;

    // Second header flit: sender and port ride above the Y hop count
    typedef struct packed {
        node_t origin;
        port_t port;
        hop_t  yh;
    } yhdr_t;

    function automatic flit_t make_xhdr(input hop_t x);
        return {{(FLIT_W-HOP_W){1'b0}}, x};
    endfunction

    function automatic flit_t make_yhdr(input node_t o, input port_t p, input hop_t y);
        yhdr_t h;
        h.origin = o;
        h.port   = p;
        h.yh     = y;
        return flit_t'(h);
    endfunction

endpackage

// File: rtl/ni_msg_ram.sv
module ni_msg_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ni_route_table.sv
module ni_route_table import ni_pkg::*; #(
    parameter int LADDR_W = LADDR_W_DEF,
    localparam int NENT   = 2 ** LADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LADDR_W-1:0] wr_addr,
    input  route_t             wr_entry,
    input  logic [LADDR_W-1:0] lk_addr,
    output route_t             lk_entry
);

    route_t tbl [NENT];

    generate
        for (genvar g = 0; g < NENT; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)                                    tbl[g] <= '0;
                else if (wr_en && wr_addr == LADDR_W'(g))   tbl[g] <= wr_entry;
            end
        end
    endgenerate

    assign lk_entry = tbl[lk_addr];

    // R2
    tbl_update_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && lk_addr == $past(wr_addr))
        |-> lk_entry == $past(wr_entry));

endmodule

// File: rtl/ni_tx_path.sv
module ni_tx_path import ni_pkg::*; #(
    parameter int    MAX_LEN = MAX_LEN_DEF,
    parameter int    NBUF    = NBUF_DEF,
    parameter int    LADDR_W = LADDR_W_DEF,
    parameter node_t NODE_ID = '0,
    localparam int   LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mo_valid,
    output logic               mo_ready,
    input  logic [LADDR_W-1:0] mo_dst,
    input  port_t              mo_port,
    input  logic [LEN_W-1:0]   mo_len,
    input  flit_t              mo_data,
    output logic               mo_err,
    output logic [LADDR_W-1:0] lk_addr,
    input  route_t             lk_entry,
    output logic               net_tx_valid,
    input  logic               net_tx_nack,
    output flit_t              net_tx_flit,
    output logic               net_tx_last
);

    localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CNT_W = $clog2(NBUF + 1);
    localparam int IDX_W = $clog2(MAX_LEN + 4);
    localparam int DEPTH = NBUF * MAX_LEN;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        hop_t             xh;
        hop_t             yh;
        port_t            port;
    } txc_t;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NBUF - 1)) ? '0 : p + 1'b1;
    endfunction

    txc_t               ctrl [NBUF];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   cnt;
    logic [LEN_W-1:0]   fill_idx, fill_len;
    logic               fill_drop;
    logic [IDX_W-1:0]   send_idx;

    logic               acc, first, last_in, drop_now, commit, done;
    logic [LEN_W-1:0]   cur_len;
    logic [AW-1:0]      waddr, raddr;
    logic [IDX_W-1:0]   data_off, slen2;
    flit_t              rd_flit;
    txc_t               cur;

    // ---- fill side (task) ----
    assign lk_addr  = mo_dst;
    assign mo_ready = (cnt != CNT_W'(NBUF));
    assign acc      = mo_valid && mo_ready;
    assign first    = (fill_idx == '0);
    assign cur_len  = first ? mo_len : fill_len;
    assign last_in  = acc && (fill_idx == cur_len - LEN_W'(1));
    assign drop_now = first ? !lk_entry.vld : fill_drop;
    assign commit   = last_in && !drop_now;
    assign waddr    = AW'(int'(wr_ptr) * MAX_LEN + int'(fill_idx));

    // ---- send side (router) ----
    assign cur          = ctrl[rd_ptr];
    assign net_tx_valid = (cnt != '0);
    assign slen2        = IDX_W'(cur.len) + IDX_W'(2);
    assign data_off     = send_idx - IDX_W'(2);
    assign raddr        = AW'(int'(rd_ptr) * MAX_LEN + int'(data_off));
    assign net_tx_last  = net_tx_valid && (send_idx == slen2 + IDX_W'(1));
    assign done         = net_tx_valid && !net_tx_nack && net_tx_last;

    always_comb begin
        if (send_idx == IDX_W'(0))      net_tx_flit = make_xhdr(cur.xh);
        else if (send_idx == IDX_W'(1)) net_tx_flit = make_yhdr(NODE_ID, cur.port, cur.yh);
        else if (send_idx < slen2)      net_tx_flit = rd_flit;
        else if (send_idx == slen2)     net_tx_flit = FLIT_W'(cur.len);
        else                            net_tx_flit = ~FLIT_W'(cur.len);
    end

    ni_msg_ram #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (acc),
        .waddr (waddr),
        .wdata (mo_data),
        .raddr (raddr),
        .rdata (rd_flit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            cnt       <= '0;
            fill_idx  <= '0;
            fill_len  <= '0;
            fill_drop <= 1'b0;
            send_idx  <= '0;
            mo_err    <= 1'b0;
            for (int i = 0; i < NBUF; i++) ctrl[i] <= '0;
        end else begin
            mo_err <= acc && first && !lk_entry.vld;
            if (acc) begin
                if (first) begin
                    fill_len  <= mo_len;
                    fill_drop <= !lk_entry.vld;
                    ctrl[wr_ptr] <= '{len: mo_len, xh: lk_entry.xh,
                                      yh: lk_entry.yh, port: mo_port};
                end
                fill_idx <= last_in ? '0 : fill_idx + LEN_W'(1);
            end
            if (commit) wr_ptr <= ring_next(wr_ptr);
            if (net_tx_valid && !net_tx_nack) begin
                if (net_tx_last) begin
                    send_idx <= '0;
                    rd_ptr   <= ring_next(rd_ptr);
                end else begin
                    send_idx <= send_idx + IDX_W'(1);
                end
            end
            cnt <= cnt + CNT_W'(commit) - CNT_W'(done);
        end
    end

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (net_tx_valid && net_tx_nack) |=>
        (net_tx_valid && $stable(net_tx_flit) && $stable(net_tx_last)));

    // R5
    no_early_send_chk: assert property (@(posedge clk) disable iff (rst)
        net_tx_valid |-> !(fill_idx != '0 && wr_ptr == rd_ptr));

    // R3
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        mo_err |-> $past(mo_valid && mo_ready));

    // R6
    full_waits_chk: assert property (@(posedge clk) disable iff (rst)
        !mo_ready |-> net_tx_valid);

endmodule

// File: rtl/ni_rx_path.sv
module ni_rx_path import ni_pkg::*; #(
    parameter int  MAX_LEN = MAX_LEN_DEF,
    parameter int  NBUF    = NBUF_DEF,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             net_rx_valid,
    output logic             net_rx_nack,
    input  flit_t            net_rx_flit,
    input  logic             net_rx_last,
    output logic             mi_valid,
    input  logic             mi_ready,
    output logic [LEN_W-1:0] mi_len,
    output node_t            mi_origin,
    output port_t            mi_port,
    output flit_t            mi_data,
    output logic             mi_last
);

    localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CNT_W = $clog2(NBUF + 1);
    localparam int IDX_W = $clog2(MAX_LEN + 4);
    localparam int SLOT  = MAX_LEN + 2;
    localparam int DEPTH = NBUF * SLOT;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        node_t            origin;
        port_t            port;
    } rxc_t;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NBUF - 1)) ? '0 : p + 1'b1;
    endfunction

    rxc_t               ctrl [NBUF];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   rx_idx;
    logic [LEN_W-1:0]   rd_idx;

    logic               acc, take, rx_done, rd_done;
    yhdr_t              hdr;
    logic [AW-1:0]      waddr, raddr;
    rxc_t               cur;
    logic               rx_unused_yh;

    assign net_rx_nack  = (cnt == CNT_W'(NBUF));
    assign acc          = net_rx_valid && !net_rx_nack;
    assign rx_done      = acc && net_rx_last;
    assign hdr          = yhdr_t'(net_rx_flit);
    assign rx_unused_yh = ^hdr.yh;
    assign waddr        = AW'(int'(wr_ptr) * SLOT + int'(rx_idx) - 1);

    assign cur       = ctrl[rd_ptr];
    assign mi_valid  = (cnt != '0);
    assign mi_len    = cur.len;
    assign mi_origin = cur.origin;
    assign mi_port   = cur.port;
    assign mi_last   = mi_valid && (rd_idx == cur.len - LEN_W'(1));
    assign raddr     = AW'(int'(rd_ptr) * SLOT + int'(rd_idx));
    assign take      = mi_valid && mi_ready;
    assign rd_done   = take && mi_last;

    ni_msg_ram #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (acc && rx_idx != '0),
        .waddr (waddr),
        .wdata (net_rx_flit),
        .raddr (raddr),
        .rdata (mi_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            rx_idx <= '0;
            rd_idx <= '0;
            for (int i = 0; i < NBUF; i++) ctrl[i] <= '0;
        end else begin
            if (acc) begin
                if (rx_idx == '0) begin
                    ctrl[wr_ptr].origin <= hdr.origin;
                    ctrl[wr_ptr].port   <= hdr.port;
                end
                if (net_rx_last) begin
                    ctrl[wr_ptr].len <= LEN_W'(rx_idx - IDX_W'(2));
                    wr_ptr <= ring_next(wr_ptr);
                    rx_idx <= '0;
                end else begin
                    rx_idx <= rx_idx + IDX_W'(1);
                end
            end
            if (take) begin
                if (mi_last) begin
                    rd_idx <= '0;
                    rd_ptr <= ring_next(rd_ptr);
                end else begin
                    rd_idx <= rd_idx + LEN_W'(1);
                end
            end
            cnt <= cnt + CNT_W'(rx_done) - CNT_W'(rd_done);
        end
    end

    // R11
    mi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mi_valid && !mi_ready) |=>
        (mi_valid && $stable(mi_data) && $stable(mi_len) &&
         $stable(mi_origin) && $stable(mi_port) && $stable(mi_last)));

    // R9
    nack_pending_chk: assert property (@(posedge clk) disable iff (rst)
        net_rx_nack |-> mi_valid);

    // R10
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !mi_last) |=> $stable(rd_ptr));

endmodule

// File: rtl/network_iface.sv
module network_iface import ni_pkg::*; #(
    parameter int    MAX_LEN = MAX_LEN_DEF,
    parameter int    NBUF    = NBUF_DEF,
    parameter int    LADDR_W = LADDR_W_DEF,
    parameter node_t NODE_ID = 8'h5A
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tbl_wr_en,
    input  logic [LADDR_W-1:0]           tbl_wr_addr,
    input  logic                         tbl_wr_vld,
    input  logic [HOP_W-1:0]             tbl_wr_x,
    input  logic [HOP_W-1:0]             tbl_wr_y,
    input  logic                         mo_valid,
    output logic                         mo_ready,
    input  logic [LADDR_W-1:0]           mo_dst,
    input  logic [PORT_W-1:0]            mo_port,
    input  logic [$clog2(MAX_LEN+1)-1:0] mo_len,
    input  logic [FLIT_W-1:0]            mo_data,
    output logic                         mo_err,
    output logic                         net_tx_valid,
    input  logic                         net_tx_nack,
    output logic [FLIT_W-1:0]            net_tx_flit,
    output logic                         net_tx_last,
    input  logic                         net_rx_valid,
    output logic                         net_rx_nack,
    input  logic [FLIT_W-1:0]            net_rx_flit,
    input  logic                         net_rx_last,
    output logic                         mi_valid,
    input  logic                         mi_ready,
    output logic [$clog2(MAX_LEN+1)-1:0] mi_len,
    output logic [NODE_W-1:0]            mi_origin,
    output logic [PORT_W-1:0]            mi_port,
    output logic [FLIT_W-1:0]            mi_data,
    output logic                         mi_last
);

    logic [LADDR_W-1:0] lk_addr;
    route_t             lk_entry;
    route_t             wr_entry;

    assign wr_entry = '{vld: tbl_wr_vld, xh: tbl_wr_x, yh: tbl_wr_y};

    ni_route_table #(.LADDR_W(LADDR_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr_en),
        .wr_addr  (tbl_wr_addr),
        .wr_entry (wr_entry),
        .lk_addr  (lk_addr),
        .lk_entry (lk_entry)
    );

    ni_tx_path #(.MAX_LEN(MAX_LEN), .NBUF(NBUF), .LADDR_W(LADDR_W), .NODE_ID(NODE_ID)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .mo_valid     (mo_valid),
        .mo_ready     (mo_ready),
        .mo_dst       (mo_dst),
        .mo_port      (mo_port),
        .mo_len       (mo_len),
        .mo_data      (mo_data),
        .mo_err       (mo_err),
        .lk_addr      (lk_addr),
        .lk_entry     (lk_entry),
        .net_tx_valid (net_tx_valid),
        .net_tx_nack  (net_tx_nack),
        .net_tx_flit  (net_tx_flit),
        .net_tx_last  (net_tx_last)
    );

    ni_rx_path #(.MAX_LEN(MAX_LEN), .NBUF(NBUF)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .net_rx_valid (net_rx_valid),
        .net_rx_nack  (net_rx_nack),
        .net_rx_flit  (net_rx_flit),
        .net_rx_last  (net_rx_last),
        .mi_valid     (mi_valid),
        .mi_ready     (mi_ready),
        .mi_len       (mi_len),
        .mi_origin    (mi_origin),
        .mi_port      (mi_port),
        .mi_data      (mi_data),
        .mi_last      (mi_last)
    );

endmodule

// File: tb/network_iface_tb.sv
`timescale 1ns/1ps
module network_iface_tb;

    localparam logic [7:0] NID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_wr_en, tbl_wr_vld;
    logic [2:0]  tbl_wr_addr;
    logic [3:0]  tbl_wr_x, tbl_wr_y;
    logic        mo_valid, mo_ready, mo_err;
    logic [2:0]  mo_dst;
    logic [3:0]  mo_port;
    logic [7:0]  mo_len;
    logic [15:0] mo_data;
    logic        net_tx_valid, net_tx_nack, net_tx_last;
    logic [15:0] net_tx_flit;
    logic        net_rx_valid, net_rx_nack, net_rx_last;
    logic [15:0] net_rx_flit;
    logic        mi_valid, mi_ready, mi_last;
    logic [7:0]  mi_len, mi_origin;
    logic [3:0]  mi_port;
    logic [15:0] mi_data;

    always #2.5 clk = ~clk;

    network_iface #(.NODE_ID(NID)) u_dut (
        .clk, .rst, .tbl_wr_en, .tbl_wr_addr, .tbl_wr_vld, .tbl_wr_x, .tbl_wr_y,
        .mo_valid, .mo_ready, .mo_dst, .mo_port, .mo_len, .mo_data, .mo_err,
        .net_tx_valid, .net_tx_nack, .net_tx_flit, .net_tx_last,
        .net_rx_valid, .net_rx_nack, .net_rx_flit, .net_rx_last,
        .mi_valid, .mi_ready, .mi_len, .mi_origin, .mi_port, .mi_data, .mi_last
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [15:0] dat [4][128];
    int          mlen [4];
    logic [3:0]  mport [4];
    logic [2:0]  maddr [4];
    logic [7:0]  morg [4];
    logic [3:0]  ex [4];
    logic [3:0]  ey [4];
    logic [3:0]  tx_x [8];
    logic [3:0]  tx_y [8];
    bit          tv [8];

    function automatic logic [15:0] exp_x(input logic [3:0] x);
        return {12'h000, x};
    endfunction

    function automatic logic [15:0] exp_y(input logic [7:0] o, input logic [3:0] p, input logic [3:0] y);
        return {o, p, y};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_msg(input int s, input int len, input logic [2:0] a);
        mlen[s]  = len;
        maddr[s] = a;
        mport[s] = 4'($urandom);
        morg[s]  = 8'($urandom);
        for (int i = 0; i < len; i++) dat[s][i] = 16'($urandom);
    endtask

    task automatic tbl_write(input logic [2:0] a, input bit v, input logic [3:0] x, input logic [3:0] y);
        tbl_wr_en = 1; tbl_wr_addr = a; tbl_wr_vld = v; tbl_wr_x = x; tbl_wr_y = y;
        @(negedge clk);
        tbl_wr_en = 0;
        tv[a] = v; tx_x[a] = x; tx_y[a] = y;
    endtask

    task automatic send_msg(input int s, input bit gap, output bit got_err);
        bit gap_ok = 1;
        got_err = 0;
        mo_dst = maddr[s]; mo_port = mport[s]; mo_len = 8'(mlen[s]);
        ex[s] = tx_x[maddr[s]]; ey[s] = tx_y[maddr[s]];
        for (int i = 0; i < mlen[s]; i++) begin
            mo_valid = 1; mo_data = dat[s][i];
            #1;
            if (gap && i > 0 && net_tx_valid) gap_ok = 0;
            while (!mo_ready) begin @(negedge clk); #1; end
            @(negedge clk);
            if (i == 0) got_err = mo_err;
        end
        mo_valid = 0;
        if (gap) begin
            chk(gap_ok, "R5", "valid during fill", 0, 0);
            #1;
            chk(net_tx_valid == tv[maddr[s]], "R5", "valid after fill", net_tx_valid, tv[maddr[s]]);
        end
    endtask

    task automatic expect_frame(input int s, input bit rnd);
        int len = mlen[s];
        logic [15:0] e;
        for (int k = 0; k < len + 4; k++) begin
            net_tx_nack = rnd ? ($urandom_range(0, 2) == 0) : 1'b0;
            #1;
            while (!(net_tx_valid && !net_tx_nack)) begin
                @(negedge clk);
                net_tx_nack = rnd ? ($urandom_range(0, 2) == 0) : 1'b0;
                #1;
            end
            if (k == 0)            e = exp_x(ex[s]);
            else if (k == 1)       e = exp_y(NID, mport[s], ey[s]);
            else if (k < len + 2)  e = dat[s][k-2];
            else if (k == len + 2) e = 16'(len);
            else                   e = ~16'(len);
            chk(net_tx_flit == e, (k < 2) ? "R1" : "R4", "tx flit", net_tx_flit, e);
            chk(net_tx_last == (k == len + 3), "R4", "tx last", net_tx_last, (k == len + 3));
            @(negedge clk);
        end
        net_tx_nack = 0;
    endtask

    task automatic drive_rx(input int s);
        int len = mlen[s];
        for (int k = 0; k < len + 3; k++) begin
            net_rx_valid = 1;
            net_rx_last  = (k == len + 2);
            if (k == 0)            net_rx_flit = {morg[s], mport[s], 4'h0};
            else if (k <= len)     net_rx_flit = dat[s][k-1];
            else if (k == len + 1) net_rx_flit = 16'(len);
            else                   net_rx_flit = ~16'(len);
            #1;
            while (net_rx_nack) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        net_rx_valid = 0; net_rx_last = 0;
    endtask

    task automatic read_rx(input int s, input bit rnd);
        int len = mlen[s];
        for (int k = 0; k < len; k++) begin
            mi_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            while (!(mi_valid && mi_ready)) begin
                @(negedge clk);
                mi_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
                #1;
            end
            if (k == 0) begin
                chk(mi_len == 8'(len), "R8", "mi_len", mi_len, len);
                chk(mi_origin == morg[s], "R8", "mi_origin", mi_origin, morg[s]);
                chk(mi_port == mport[s], "R8", "mi_port", mi_port, mport[s]);
            end
            chk(mi_data == dat[s][k], "R10", "mi_data", mi_data, dat[s][k]);
            chk(mi_last == (k == len - 1), "R8", "mi_last", mi_last, (k == len - 1));
            @(negedge clk);
        end
        mi_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        bit err;
        logic [15:0] held;
        void'($urandom(32'd20240611));
        rst = 1; tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_vld = 0; tbl_wr_x = 0; tbl_wr_y = 0;
        mo_valid = 0; mo_dst = 0; mo_port = 0; mo_len = 0; mo_data = 0;
        net_tx_nack = 0; net_rx_valid = 0; net_rx_flit = 0; net_rx_last = 0; mi_ready = 0;
        for (int i = 0; i < 8; i++) begin tv[i] = 0; tx_x[i] = 0; tx_y[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R12 reset state
        chk(!net_tx_valid && !mi_valid && !net_rx_nack && !mo_err, "R12", "idle outputs", 0, 0);
        chk(mo_ready, "R12", "mo_ready", mo_ready, 1);
        @(negedge clk);

        // R12: empty table means any destination misses
        fill_msg(0, 2, 3'd4);
        send_msg(0, 0, err);
        chk(err, "R12", "empty table miss", err, 1);
        repeat (2) @(negedge clk);

        // R1/R4/R5 directed
        tbl_write(3'd3, 1, 4'd2, 4'd1);
        fill_msg(0, 3, 3'd3);
        send_msg(0, 1, err);
        chk(!err, "R3", "no error on hit", err, 0);
        expect_frame(0, 0);

        // R3 miss: error pulse, nothing sent
        fill_msg(1, 4, 3'd7);
        send_msg(1, 0, err);
        chk(err, "R3", "mo_err pulse", err, 1);
        chk(!mo_err, "R3", "mo_err one cycle", mo_err, 0);
        repeat (5) @(negedge clk);
        chk(!net_tx_valid && mo_ready, "R3", "dropped message", net_tx_valid, 0);

        // R6/R2: two waiting, table rewrite between them
        net_tx_nack = 1;
        fill_msg(0, 5, 3'd3);
        send_msg(0, 0, err);
        tbl_write(3'd3, 1, 4'd9, 4'd6);
        chk(mo_ready, "R2", "rewrite does not stall", mo_ready, 1);
        fill_msg(1, 2, 3'd3);
        send_msg(1, 0, err);
        #1;
        chk(!mo_ready, "R6", "both buffers waiting", mo_ready, 0);
        // R7 hold under back-pressure
        held = net_tx_flit;
        @(negedge clk); #1;
        chk(net_tx_valid && net_tx_flit == held, "R7", "held flit", net_tx_flit, held);
        chk(held == exp_x(4'd2), "R2", "old entry kept", held, exp_x(4'd2));
        @(negedge clk);
        expect_frame(0, 1);
        expect_frame(1, 1);

        // max length transmit
        tbl_write(3'd5, 1, 4'd15, 4'd15);
        fill_msg(2, 128, 3'd5);
        send_msg(2, 1, err);
        expect_frame(2, 1);

        // R8/R9/R10 receive directed
        fill_msg(0, 3, 3'd0);
        fill_msg(1, 6, 3'd0);
        drive_rx(0);
        #1;
        chk(!net_rx_nack && mi_valid, "R9", "one buffer used", net_rx_nack, 0);
        drive_rx(1);
        #1;
        chk(net_rx_nack, "R9", "nack when full", net_rx_nack, 1);
        // R11 hold while not ready
        held = mi_data;
        @(negedge clk); #1;
        chk(mi_valid && mi_data == held && mi_len == 8'd3, "R11", "mi hold", mi_data, held);
        @(negedge clk);
        read_rx(0, 0);
        #1;
        chk(!net_rx_nack, "R9", "nack released", net_rx_nack, 0);
        @(negedge clk);
        read_rx(1, 1);
        fill_msg(3, 128, 3'd0);
        drive_rx(3);
        read_rx(3, 1);

        // random transmit
        for (int i = 0; i < 6; i++) tbl_write(3'(i), 1, 4'($urandom), 4'($urandom));
        for (int it = 0; it < 20; it++) begin
            if ($urandom_range(0, 5) == 0) tbl_write(3'($urandom_range(0, 5)), 1, 4'($urandom), 4'($urandom));
            fill_msg(0, $urandom_range(1, 40), 3'($urandom_range(0, 5)));
            send_msg(0, 1, err);
            chk(!err, "R3", "random hit", err, 0);
            expect_frame(0, 1);
        end

        // random receive, two at a time
        for (int it = 0; it < 8; it++) begin
            fill_msg(0, $urandom_range(1, 60), 3'd0);
            fill_msg(1, $urandom_range(1, 60), 3'd0);
            drive_rx(0);
            drive_rx(1);
            read_rx(0, 1);
            read_rx(1, 1);
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule